// File: doc/BRIEF.md
# B3ZS Line Encoder with Single-Shot Violation Injector

This block turns a serial NRZ bit stream at DS3 rate (44.736 Mbit/s, one bit per asserted clock enable) into a pair of line rails. In bipolar mode the marks alternate in polarity, and every run of three zeros is replaced by a B3ZS substitution code. The code chosen depends on the pulse parity counted since the previous substitution. In unipolar mode the data appears unchanged on the positive rail, and the negative rail stays low.

A test request can force exactly one bipolar violation into the bipolar stream. The violation goes on the next data mark, which is then sent with the same polarity as the pulse before it. The request is edge-triggered. A busy flag shows that a violation is armed, and a one-clock acknowledge marks the clock in which the violating pulse reaches the rails. The encoder looks three bits ahead, so every bit reaches the rails exactly three enables after it is accepted.

Top module: `b3zs_line_encoder`

## Requirements
- R1: After reset both rails, the busy flag and the acknowledge are low. The pulse parity starts even, and the first pulse sent in bipolar mode is positive.
- R2: With the mode bit low (unipolar), the positive rail carries the data bit (1 = high) and the negative rail stays low. No zero substitution takes place.
- R3: With the mode bit high (bipolar), each data one is a pulse of the opposite polarity to the previous pulse. A positive pulse is rail_pos=1, rail_neg=0. A negative pulse is rail_pos=0, rail_neg=1. No pulse is both rails low.
- R4: In bipolar mode, three consecutive data zeros sent after an even number of pulses since the last substitution become B0V. B alternates normally, and V has the same polarity as B.
- R5: In bipolar mode, three consecutive data zeros sent after an odd number of pulses since the last substitution become 00V, with V the same polarity as the previous pulse.
- R6: The pulse parity is cleared by each substitution, so two back-to-back zero runs give B0V twice with opposite polarities.
- R7: A bit accepted on an enable reaches the rails on the third enable after it. The rails change only on clocks with the enable high.
- R8: A rising edge on err_req while nothing is armed sets err_busy on the next clock. The next data one emitted in bipolar mode is then sent with the same polarity as the previous pulse. err_ack is high for exactly that one clock, err_busy clears, and later ones resume alternation from the violating pulse.
- R9: Holding err_req high, or raising it again while err_busy is high, adds no further violation.
- R10: rail_pos and rail_neg are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-period clock enable, one data bit per high cycle |
| nrz_in | input | 1 | Serial NRZ data |
| bipolar_mode | input | 1 | 1 = B3ZS bipolar rails, 0 = unipolar on the positive rail |
| err_req | input | 1 | Violation insertion request, edge-triggered |
| rail_pos | output | 1 | Positive rail |
| rail_neg | output | 1 | Negative rail |
| err_busy | output | 1 | A violation is armed and waiting for a data one |
| err_ack | output | 1 | One-clock pulse when the violating pulse is emitted |

## Verification
The hardest state to reach is a violation armed while marks are already in the lookahead window, followed by a second request edge before the first one is used up. The bench fills the window with ones, raises the request between enables and checks the busy flag. It then pulses the request low and high again without any enable, so that the second edge lands while busy is high. Only one same-polarity pulse may follow. The substitution codes are reached from reset with chosen eight-bit patterns, which set the parity to odd or even before each zero run.

// File: rtl/b3zs_pkg.sv
package b3zs_pkg;

  // Lookahead depth equals the zero-run length replaced by one code.
  localparam int unsigned RUN_LEN = 3;

  // Symbol held in each lookahead slot.
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,  // data zero, still eligible for substitution
    SYM_ONE  = 2'd1,  // data one
    SYM_VIOL = 2'd2,  // V slot of a substitution already decided
    SYM_IDLE = 2'd3   // reset filler, never emitted as a pulse
  } sym_t;

  // First slot of a substitution carries a pulse (B) when parity is even.
  function automatic logic lead_carries_pulse(input logic parity_odd);
    return !parity_odd;
  endfunction

  // Polarity (1 = negative) of a mark, given the previous pulse polarity.
  function automatic logic mark_polarity(input logic prev_neg, input logic force_repeat);
    return force_repeat ? prev_neg : !prev_neg;
  endfunction

endpackage

// File: rtl/b3zs_req_arm.sv
module b3zs_req_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic consume,
  output logic armed,
  output logic req_rise
);
  logic req_q;

  assign req_rise = req_in && !req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      armed <= 1'b0;
    end else begin
      req_q <= req_in;
      if (consume)       armed <= 1'b0;
      else if (req_rise) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/b3zs_window.sv
module b3zs_window
  import b3zs_pkg::*;
#(
  parameter int unsigned DEPTH = RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bit_in,
  input  logic mark_v,
  output sym_t head,
  output logic run_zero
);
  localparam int VSLOT = int'(DEPTH) - 2;

  sym_t stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)        stage[0] <= SYM_IDLE;
    else if (shift_en) stage[0] <= bit_in ? SYM_ONE : SYM_ZERO;
  end

  for (genvar g = 1; g < int'(DEPTH); g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)
        stage[g] <= SYM_IDLE;
      else if (shift_en)
        stage[g] <= (g == VSLOT && mark_v) ? SYM_VIOL : stage[g-1];
    end
  end

  always_comb begin
    run_zero = 1'b1;
    for (int i = 0; i < int'(DEPTH); i++)
      if (stage[i] != SYM_ZERO) run_zero = 1'b0;
  end

  assign head = stage[DEPTH-1];
endmodule

// File: rtl/b3zs_emit.sv
module b3zs_emit
  import b3zs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bipolar,
  input  sym_t head,
  input  logic run_zero,
  input  logic inj_armed,
  output logic sub_start,
  output logic inj_fire,
  output logic parity_odd,
  output logic rail_pos,
  output logic rail_neg,
  output logic ack
);
  logic last_neg;
  logic pulse;
  logic pol_neg;
  logic head_one;

  assign head_one  = (head == SYM_ONE);
  assign sub_start = bipolar && run_zero;
  assign inj_fire  = shift_en && bipolar && head_one && inj_armed;

  always_comb begin
    pulse   = 1'b0;
    pol_neg = 1'b0;
    if (bipolar) begin
      if (sub_start) begin
        pulse   = lead_carries_pulse(parity_odd);
        pol_neg = mark_polarity(last_neg, 1'b0);
      end else if (head_one) begin
        pulse   = 1'b1;
        pol_neg = mark_polarity(last_neg, inj_armed);
      end else if (head == SYM_VIOL) begin
        pulse   = 1'b1;
        pol_neg = mark_polarity(last_neg, 1'b1);
      end
    end else begin
      pulse = head_one;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rail_pos   <= 1'b0;
      rail_neg   <= 1'b0;
      last_neg   <= 1'b1;
      parity_odd <= 1'b0;
      ack        <= 1'b0;
    end else begin
      ack <= inj_fire;
      if (shift_en) begin
        rail_pos <= pulse && !pol_neg;
        rail_neg <= pulse && pol_neg;
        if (bipolar && pulse) last_neg <= pol_neg;
        if (sub_start)                parity_odd <= 1'b0;
        else if (bipolar && head_one) parity_odd <= !parity_odd;
      end
    end
  end
endmodule

// File: rtl/b3zs_line_encoder.sv
module b3zs_line_encoder
  import b3zs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic nrz_in,
  input  logic bipolar_mode,
  input  logic err_req,
  output logic rail_pos,
  output logic rail_neg,
  output logic err_busy,
  output logic err_ack
);
  sym_t head;
  logic run_zero;
  logic sub_start;
  logic inj_fire;
  logic parity_odd;
  logic req_rise;

  b3zs_req_arm u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (err_req),
    .consume  (inj_fire),
    .armed    (err_busy),
    .req_rise (req_rise)
  );

  b3zs_window #(.DEPTH(RUN_LEN)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (bit_en),
    .bit_in   (nrz_in),
    .mark_v   (sub_start),
    .head     (head),
    .run_zero (run_zero)
  );

  b3zs_emit u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (bit_en),
    .bipolar    (bipolar_mode),
    .head       (head),
    .run_zero   (run_zero),
    .inj_armed  (err_busy),
    .sub_start  (sub_start),
    .inj_fire   (inj_fire),
    .parity_odd (parity_odd),
    .rail_pos   (rail_pos),
    .rail_neg   (rail_neg),
    .ack        (err_ack)
  );
endmodule

// File: rtl/b3zs_line_encoder_chk.sv
module b3zs_line_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic bipolar_mode,
  input logic err_req,
  input logic rail_pos,
  input logic rail_neg,
  input logic err_busy,
  input logic err_ack,
  input logic sub_start,
  input logic inj_fire,
  input logic parity_odd
);
  p_rails_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail_pos && rail_neg));

  p_unipolar_neg_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !bipolar_mode) |=> !rail_neg);

  p_hold_without_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(rail_pos) && $stable(rail_neg)));

  p_ack_single_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_ack |=> !err_ack);

  p_ack_follows_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire |=> (err_ack && !err_busy));

  p_arm_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_req) && !err_busy) |=> err_busy);

  p_even_lead_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sub_start && !parity_odd) |=> (rail_pos || rail_neg));

  p_odd_lead_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sub_start && parity_odd) |=> !(rail_pos || rail_neg));

  p_parity_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sub_start) |=> !parity_odd);
endmodule

bind b3zs_line_encoder b3zs_line_encoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_en       (bit_en),
  .bipolar_mode (bipolar_mode),
  .err_req      (err_req),
  .rail_pos     (rail_pos),
  .rail_neg     (rail_neg),
  .err_busy     (err_busy),
  .err_ack      (err_ack),
  .sub_start    (sub_start),
  .inj_fire     (inj_fire),
  .parity_odd   (parity_odd)
);

// File: tb/b3zs_line_encoder_test.sv
module b3zs_line_encoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic nrz_in = 1'b0;
  logic bipolar_mode = 1'b1;
  logic err_req = 1'b0;
  logic rail_pos, rail_neg, err_busy, err_ack;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  b3zs_line_encoder uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .nrz_in(nrz_in),
    .bipolar_mode(bipolar_mode), .err_req(err_req),
    .rail_pos(rail_pos), .rail_neg(rail_neg),
    .err_busy(err_busy), .err_ack(err_ack)
  );

  // {bipolar, data (first bit = MSB), expected pos, expected neg}
  localparam logic [24:0] VECS [6] = '{
    {1'b1, 8'b1011_0110, 8'b1001_0010, 8'b0010_0100},  // R3 plain alternation
    {1'b1, 8'b0000_0000, 8'b1010_0000, 8'b0001_0100},  // R4 R6 B0V twice
    {1'b1, 8'b1000_1000, 8'b1001_0000, 8'b0000_1001},  // R5 00V twice
    {1'b1, 8'b1100_0100, 8'b1010_1000, 8'b0100_0100},  // R4 after even parity
    {1'b0, 8'b1000_0001, 8'b1000_0001, 8'b0000_0000},  // R2 unipolar
    {1'b1, 8'b1110_0011, 8'b1010_0101, 8'b0100_0010}   // R5 after odd parity
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; err_req = 1'b0; nrz_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One enable; returns at the next falling edge with outputs of that enable.
  task automatic send_bit(input logic b);
    @(negedge clk);
    nrz_in = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  // Check one emitted mark: neg=1 means negative pulse; ack expected as given.
  task automatic expect_mark(input string req, input logic neg, input logic ack);
    check(req, {rail_pos, rail_neg}, {!neg, neg});
    check(req, {1'b0, err_ack}, {1'b0, ack});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    @(negedge clk);
    check("R1 rails", {rail_pos, rail_neg}, 2'b00);
    check("R1 busy/ack", {err_busy, err_ack}, 2'b00);

    // Table walk
    for (int v = 0; v < 6; v++) begin
      do_reset();
      bipolar_mode = VECS[v][24];
      for (int n = 0; n < 11; n++) begin
        send_bit(n < 8 ? VECS[v][23 - n] : 1'b1);
        if (n >= 3)
          check($sformatf("R3/R4/R5/R2 vec%0d slot%0d", v, n - 3),
                {rail_pos, rail_neg},
                {VECS[v][15 - (n - 3)], VECS[v][7 - (n - 3)]});
        else
          check("R7 latency fill", {rail_pos, rail_neg}, 2'b00);
      end
    end

    // R7 and R1: first pulse positive after three enables, then hold without enable
    do_reset();
    bipolar_mode = 1'b1;
    for (int n = 0; n < 4; n++) send_bit(1'b1);
    check("R1 first pulse positive", {rail_pos, rail_neg}, 2'b10);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      nrz_in = k[0];
      bipolar_mode = k[0];
      check("R7 hold without enable", {rail_pos, rail_neg}, 2'b10);
    end
    bipolar_mode = 1'b1;

    // R8 injection on a stream of ones
    do_reset();
    bipolar_mode = 1'b1;
    for (int n = 0; n < 4; n++) send_bit(1'b1);   // slot0 = +
    @(negedge clk); err_req = 1'b1;
    @(negedge clk);
    check("R8 busy after edge", {1'b0, err_busy}, 2'b01);
    send_bit(1'b1);
    expect_mark("R8 violation repeats +", 1'b0, 1'b1);
    check("R8 busy cleared", {1'b0, err_busy}, 2'b00);
    send_bit(1'b1);
    expect_mark("R8 alternation resumes", 1'b1, 1'b0);
    send_bit(1'b1);
    expect_mark("R9 held request no repeat", 1'b0, 1'b0);
    send_bit(1'b1);
    expect_mark("R9 held request no repeat", 1'b1, 1'b0);

    // R9 second edge while busy is ignored
    @(negedge clk); err_req = 1'b0;
    @(negedge clk); err_req = 1'b1;
    @(negedge clk); err_req = 1'b0;
    @(negedge clk); err_req = 1'b1;
    @(negedge clk);
    check("R9 busy while armed", {1'b0, err_busy}, 2'b01);
    send_bit(1'b1);
    expect_mark("R8 second violation repeats -", 1'b1, 1'b1);
    send_bit(1'b1);
    expect_mark("R9 only one violation", 1'b0, 1'b0);
    send_bit(1'b1);
    expect_mark("R9 only one violation", 1'b1, 1'b0);
    check("R10 busy idle", {1'b0, err_busy}, 2'b00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule